// File: doc/BRIEF.md
# Three-Level Inverter Delayed Shutdown Sequencer

This block protects one leg of a neutral-point-clamped three-level inverter. It sits between four PWM gate commands and the four gate drive outputs. The two outer switches are S1 and S4, and the two inner switches are S2 and S3. In normal operation the gates follow PWM. In the positive half-cycle S2 stays on and S4 stays off while S1 and S3 alternate. In the negative half-cycle S3 stays on and S1 stays off while S2 and S4 alternate.

A fault request is the OR of several hardware trip inputs and a software shutdown bit. Every source produces the same sequence. When the fault is seen, the outer gates drop in that same cycle. The inner gates drop only after a programmable delay. After the fault has gone and a clear strobe is given, the inner gates are restored first. Once a second programmable delay has run out, the outer gates are released. Three instances cover a three-phase inverter.

The sequencer has four states:
- NORMAL (code 0): all gates follow PWM.
- OUTER_OFF (code 1): the shutdown delay is counting; the outer gates are low and the inner gates still follow PWM.
- ALL_OFF (code 2): all gates are low.
- INNER_ON (code 3): the recovery delay is counting; the inner gates follow PWM and the outer gates are low.

The transitions are:
- Trip: NORMAL to OUTER_OFF when a fault is present.
- Expire: OUTER_OFF to ALL_OFF when the shutdown count reaches zero.
- Restart: ALL_OFF to INNER_ON on a clear strobe with no fault present.
- Refault: INNER_ON to ALL_OFF when a fault is present.
- Release: INNER_ON to NORMAL when the recovery count reaches zero with no fault present.

Top module: `npc_shutdown_seq`

## Requirements
- R1: In NORMAL with no fault, gate_o equals pwm_i. Bit 0 is S1, bit 1 is S2, bit 2 is S3 and bit 3 is S4.
- R2: The fault request is the OR of all trip_i bits and sw_shutdown_i. Any one of them starts the same sequence.
- R3: In any cycle where a fault is present, gate_o bits 0 and 3 (the outer gates) are low in that same cycle.
- R4: After a fault is first seen in NORMAL, the inner gates keep following PWM for off_dly_i+1 cycles, counting the cycle in which the fault is seen, and are low from the next cycle on. A value of 0 gives a single cycle. The state reaches ALL_OFF one cycle after the inner gates drop.
- R5: In ALL_OFF, a clear_i pulse with no fault present moves the state to INNER_ON at the next edge. INNER_ON lasts on_dly_i+1 cycles, with the inner gates following PWM and the outer gates low. The state then becomes NORMAL.
- R6: In ALL_OFF all gates are low, and clear_i has no effect while a fault is present.
- R7: Once OUTER_OFF is entered, the shutdown runs to ALL_OFF even if the fault goes away during the delay.
- R8: A fault during INNER_ON drives the inner gates low in the same cycle and returns the state to ALL_OFF at the next edge.
- R9: state_o reads 0 for NORMAL, 1 for OUTER_OFF, 2 for ALL_OFF and 3 for INNER_ON. prot_active_o is high in every state except NORMAL.
- R10: Synchronous active-high rst puts the state into ALL_OFF, so all gates are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 4 | PWM commands (bit 0 = S1 .. bit 3 = S4) |
| trip_i | input | N_TRIP | Hardware trip requests, active high |
| sw_shutdown_i | input | 1 | Software shutdown command |
| clear_i | input | 1 | Restart strobe, used in ALL_OFF |
| off_dly_i | input | DLY_W | Shutdown delay in cycles |
| on_dly_i | input | DLY_W | Recovery delay in cycles |
| gate_o | output | 4 | Gate drive outputs |
| prot_active_o | output | 1 | High when the state is not NORMAL |
| state_o | output | 3 | State code |

## Verification
A state register stuck in or skipped over OUTER_OFF or INNER_ON shows at gate_o within one cycle. It appears as inner gates that drop too early or too late, or outer gates released while the inner ones are still held low. An off-by-one in the delay counter moves the edge where the inner gates fall, or where the outer gates are released, by exactly one cycle. The bench therefore samples gate_o and state_o on every cycle of each delay window. A broken fault merge or a broken combinational mask shows up in the cycle where the fault first appears, before any clock edge, so the bench checks outputs right after it drives a fault.

// File: rtl/npc_seq_pkg.sv
package npc_seq_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_OUTER_OFF = 3'd1,
        ST_ALL_OFF   = 3'd2,
        ST_INNER_ON  = 3'd3
    } seq_state_e;

    localparam int GATE_N = 4;

    function automatic logic is_outer(input int idx);
        return (idx == 0) || (idx == GATE_N - 1);
    endfunction
endpackage

// File: rtl/npc_fault_merge.sv
module npc_fault_merge #(
    parameter int N_TRIP = 4
) (
    input  logic [N_TRIP-1:0] trip_i,
    input  logic              sw_i,
    output logic              fault_o
);
    assign fault_o = (|trip_i) | sw_i;
endmodule

// File: rtl/npc_dly_counter.sv
module npc_dly_counter #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/npc_seq_fsm.sv
module npc_seq_fsm
    import npc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fault_i,
    input  logic       clear_i,
    input  logic       cnt_zero_i,
    output seq_state_e state_o,
    output logic       load_off_o,
    output logic       load_on_o,
    output logic       dec_o
);
    seq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_ALL_OFF;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_NORMAL:    if (fault_i)              st_d = ST_OUTER_OFF;
            ST_OUTER_OFF: if (cnt_zero_i)           st_d = ST_ALL_OFF;
            ST_ALL_OFF:   if (clear_i && !fault_i)  st_d = ST_INNER_ON;
            ST_INNER_ON: begin
                if (fault_i)         st_d = ST_ALL_OFF;
                else if (cnt_zero_i) st_d = ST_NORMAL;
            end
            default:                                st_d = ST_ALL_OFF;
        endcase
    end

    always_comb begin
        load_off_o = 1'b0;
        load_on_o  = 1'b0;
        dec_o      = 1'b0;
        unique case (st_q)
            ST_NORMAL:    load_off_o = fault_i;
            ST_OUTER_OFF: dec_o      = 1'b1;
            ST_ALL_OFF:   load_on_o  = clear_i && !fault_i;
            ST_INNER_ON:  dec_o      = !fault_i;
            default:      dec_o      = 1'b0;
        endcase
    end

    assign state_o = st_q;

    // R10
    reset_state_chk: assert property (@(posedge clk) rst |=> st_q == ST_ALL_OFF);

    // R7
    shutdown_commit_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_OUTER_OFF |=> (st_q == ST_OUTER_OFF || st_q == ST_ALL_OFF));

    // R8
    refault_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_INNER_ON && fault_i) |=> st_q == ST_ALL_OFF);

    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ALL_OFF && fault_i) |=> st_q == ST_ALL_OFF);
endmodule

// File: rtl/npc_gate_mask.sv
module npc_gate_mask
    import npc_seq_pkg::*;
(
    input  seq_state_e        state_i,
    input  logic              fault_i,
    input  logic              cnt_zero_i,
    input  logic [GATE_N-1:0] pwm_i,
    output logic [GATE_N-1:0] gate_o
);
    logic outer_ok, inner_ok;

    always_comb begin
        outer_ok = 1'b0;
        inner_ok = 1'b0;
        unique case (state_i)
            ST_NORMAL: begin
                outer_ok = !fault_i;
                inner_ok = 1'b1;
            end
            ST_OUTER_OFF: inner_ok = !cnt_zero_i;
            ST_INNER_ON:  inner_ok = !fault_i;
            ST_ALL_OFF:   inner_ok = 1'b0;
            default:      inner_ok = 1'b0;
        endcase
    end

    for (genvar g = 0; g < GATE_N; g++) begin : g_gate
        if (is_outer(g)) begin : g_out
            assign gate_o[g] = pwm_i[g] & outer_ok;
        end else begin : g_in
            assign gate_o[g] = pwm_i[g] & inner_ok;
        end
    end
endmodule

// File: rtl/npc_shutdown_seq.sv
module npc_shutdown_seq
    import npc_seq_pkg::*;
#(
    parameter int N_TRIP = 4,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        pwm_i,
    input  logic [N_TRIP-1:0] trip_i,
    input  logic              sw_shutdown_i,
    input  logic              clear_i,
    input  logic [DLY_W-1:0]  off_dly_i,
    input  logic [DLY_W-1:0]  on_dly_i,
    output logic [3:0]        gate_o,
    output logic              prot_active_o,
    output logic [2:0]        state_o
);
    logic       fault, cnt_zero, load_off, load_on, dec;
    seq_state_e st;

    npc_fault_merge #(.N_TRIP(N_TRIP)) u_merge (
        .trip_i (trip_i),
        .sw_i   (sw_shutdown_i),
        .fault_o(fault)
    );

    npc_dly_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_off | load_on),
        .load_val_i(load_off ? off_dly_i : on_dly_i),
        .dec_i     (dec),
        .zero_o    (cnt_zero)
    );

    npc_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault),
        .clear_i   (clear_i),
        .cnt_zero_i(cnt_zero),
        .state_o   (st),
        .load_off_o(load_off),
        .load_on_o (load_on),
        .dec_o     (dec)
    );

    npc_gate_mask u_mask (
        .state_i   (st),
        .fault_i   (fault),
        .cnt_zero_i(cnt_zero),
        .pwm_i     (pwm_i),
        .gate_o    (gate_o)
    );

    assign state_o       = st;
    assign prot_active_o = (st != ST_NORMAL);

    // R3
    outer_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((|trip_i) || sw_shutdown_i) |-> (gate_o[0] == 1'b0 && gate_o[3] == 1'b0));

    // R6
    all_off_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd2 |-> gate_o == 4'b0000);

    // R5
    recover_outer_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd3 |-> (gate_o[0] == 1'b0 && gate_o[3] == 1'b0));

    // R9
    active_flag_chk: assert property (@(posedge clk) disable iff (rst)
        prot_active_o == (state_o != 3'd0));
endmodule

// File: tb/npc_shutdown_seq_tb.sv
module npc_shutdown_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pwm = 4'hF;
    logic [3:0]  trip = 4'h0;
    logic        sw = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] offd = 16'd0;
    logic [15:0] ond = 16'd0;
    logic [3:0]  gate;
    logic        pact;
    logic [2:0]  stc;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    npc_shutdown_seq u_dut (
        .clk(clk), .rst(rst), .pwm_i(pwm), .trip_i(trip),
        .sw_shutdown_i(sw), .clear_i(clr), .off_dly_i(offd), .on_dly_i(ond),
        .gate_o(gate), .prot_active_o(pact), .state_o(stc)
    );

    // pwm pattern and expected gates in NORMAL, half-cycle patterns
    localparam logic [7:0] VEC [6] = '{
        {4'b0011, 4'b0011}, {4'b0110, 4'b0110}, {4'b1100, 4'b1100},
        {4'b0110, 4'b0110}, {4'b0000, 4'b0000}, {4'b1111, 4'b1111}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) step();
        check("R10 reset state", stc, 2);
        check("R10 reset gates", gate, 0);
        check("R9 active after reset", pact, 1);
        rst = 1'b0;

        // R6: clear ignored during fault
        trip = 4'b0001; clr = 1'b1;
        step();
        clr = 1'b0;
        check("R6 clear with fault", stc, 2);
        check("R6 gates low", gate, 0);
        trip = 4'b0000;

        // R5: recovery with on_dly=2
        ond = 16'd2; clr = 1'b1;
        step();
        clr = 1'b0; #1;
        check("R5 inner first", gate, 4'b0110);
        check("R9 code INNER_ON", stc, 3);
        step(); check("R5 hold cnt1", stc, 3);
        step(); check("R5 hold cnt0", stc, 3);
        check("R5 outer still low", gate, 4'b0110);
        step(); check("R5 release", stc, 0);
        check("R9 inactive in NORMAL", pact, 0);

        // R1: table walk
        foreach (VEC[i]) begin
            pwm = VEC[i][7:4]; #1;
            check("R1 follow pwm", gate, VEC[i][3:0]);
            step();
        end

        // R3 R4 R7 R2: trip bit 2, off_dly=3
        pwm = 4'hF; offd = 16'd3; trip = 4'b0100; #1;
        check("R3 outer drop same cycle", gate, 4'b0110);
        check("R2 trip source", stc, 0);
        step(); check("R9 code OUTER_OFF", stc, 1);
        check("R4 inner on cnt3", gate, 4'b0110);
        trip = 4'b0000;
        step(); check("R4 inner on cnt2", gate, 4'b0110);
        step(); check("R4 inner on cnt1", gate, 4'b0110);
        step(); check("R4 inner off", gate, 4'b0000);
        check("R7 still shutting down", stc, 1);
        step(); check("R7 reached ALL_OFF", stc, 2);

        // recover with on_dly=0
        ond = 16'd0; clr = 1'b1;
        step(); clr = 1'b0; #1;
        check("R5 zero recovery", stc, 3);
        step(); check("R5 NORMAL after one", stc, 0);
        check("R1 gates after recovery", gate, 4'hF);

        // R2 software source, R4 zero delay
        offd = 16'd0; sw = 1'b1; #1;
        check("R2 sw outer drop", gate, 4'b0110);
        step(); check("R4 zero delay inner off", gate, 4'b0000);
        sw = 1'b0;
        step(); check("R4 ALL_OFF after zero", stc, 2);

        // R8: refault during recovery
        ond = 16'd5; clr = 1'b1;
        step(); clr = 1'b0;
        step(); check("R8 in INNER_ON", stc, 3);
        trip = 4'b1000; #1;
        check("R8 inner drop same cycle", gate, 4'b0000);
        step(); check("R8 back to ALL_OFF", stc, 2);
        trip = 4'b0000;

        // R10: reset from NORMAL
        ond = 16'd0; clr = 1'b1;
        step(); clr = 1'b0;
        step(); check("R10 pre-reset NORMAL", stc, 0);
        rst = 1'b1;
        step(); check("R10 reset from NORMAL", stc, 2);
        check("R10 gates low", gate, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule